// File: doc/BRIEF.md
# Receive Byte Queue with RTS/CTS Flow Control

This block sits between a serial receiver and a consumer that packs bytes into larger transfers. Each received byte enters a bounded ring of entries. When the fill level climbs to a high mark, the block pulls its request-to-send line low so the remote sender pauses. It raises the line again only after the level has fallen below a separate, lower mark. Bytes that arrive while the ring is full anyway are dropped, and every drop is counted and flagged. Framing-error bytes and line breaks are stored as tagged entries in arrival order, so the consumer can tell them apart from ordinary data.

Consumer reads that find the queue empty are counted as underruns, in a counter separate from the overrun counter. Both counters stick at their maximum value and clear together on a strobe. A separate transmit stream passes through a gate controlled by the peer's clear-to-send input. The two watermarks are run-time settings. An illegal pair is replaced by defaults of three quarters and one quarter of the depth.

The flow-control state machine has two states. RTS_OPEN drives rts_o high. RTS_HELD drives it low. The transition OPEN→HELD fires when level ≥ high mark, and HELD→OPEN fires when level < low mark. No other transition exists.

Top module: `rxq_flow_top`

## Requirements
- R1: Accepted entries leave on m_data_o/m_kind_o in arrival order. An entry is popped when m_valid_o and m_ready_i are both high. m_kind_o encoding: 0 = data byte, 1 = byte with framing error (rx_ferr_i), 2 = line break (rx_break_i, which takes priority over rx_ferr_i).
- R2: By the second rising edge after the write that brings the level up to the high mark, rts_o is low.
- R3: Once low, rts_o stays low while the level is at or above the low mark. It returns high after the level falls below the low mark.
- R4: A byte offered while the queue holds DEPTH entries is dropped. ovr_cnt_o increases by one per dropped byte, and the stored entries are unchanged.
- R5: ovf_evt_o is high for exactly the one cycle that follows each cycle in which a byte was dropped.
- R6: Each cycle with m_ready_i high and m_valid_o low increments und_cnt_o. The queue contents are not affected.
- R7: A break is stored as its own entry (kind 2) between the data entries received before and after it.
- R8: While cts_i is low, tx_out_valid_o and tx_in_ready_o are low. While cts_i is high, the transmit stream passes through unchanged.
- R9: Both counters saturate at all ones. clr_i zeroes both on the next edge and takes priority over an increment.
- R10: A cfg_wr_i pulse loads cfg_hi_i/cfg_lo_i when lo < hi ≤ DEPTH. Otherwise it loads high = 3·DEPTH/4 and low = DEPTH/4.
- R11: After reset the queue is empty, rts_o is high, both counters are zero, and the watermarks hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | Received byte present |
| rx_data_i | input | 8 | Received byte |
| rx_ferr_i | input | 1 | Framing error on this byte |
| rx_break_i | input | 1 | Line break detected |
| m_valid_o | output | 1 | Queue head available |
| m_ready_i | input | 1 | Consumer takes head / read request |
| m_data_o | output | 8 | Head byte |
| m_kind_o | output | 2 | Head entry kind |
| rts_o | output | 1 | Request to send (high = peer may send) |
| cts_i | input | 1 | Clear to send from peer (high = may send) |
| tx_in_valid_i | input | 1 | Transmit byte offered |
| tx_in_data_i | input | 8 | Transmit byte |
| tx_in_ready_o | output | 1 | Transmit byte accepted |
| tx_out_valid_o | output | 1 | Byte to transmitter |
| tx_out_data_o | output | 8 | Byte to transmitter |
| tx_out_ready_i | input | 1 | Transmitter can take a byte |
| cfg_wr_i | input | 1 | Load watermarks |
| cfg_hi_i | input | LW | High watermark request |
| cfg_lo_i | input | LW | Low watermark request |
| clr_i | input | 1 | Clear both counters |
| ovr_cnt_o | output | CW | Overrun (drop) count |
| und_cnt_o | output | CW | Underrun count |
| ovf_evt_o | output | 1 | Drop event pulse |

## Verification
The queue is driven with mixed data, framing-error and break entries to check ordering and tagging. Fill and drain ramps stop exactly one entry either side of each watermark, which separates the threshold from the hysteresis. Offers into a full queue, held long enough to wrap the counter, expose lost or extra counts and saturation. Read requests into an empty queue and legal and illegal watermark writes separate underrun counting and the fallback defaults from the normal path.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        K_DATA  = 2'd0,
        K_FERR  = 2'd1,
        K_BREAK = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [BYTE_W-1:0]  data;
    } entry_t;

    typedef enum logic {
        RTS_OPEN = 1'b0,
        RTS_HELD = 1'b1
    } rts_st_e;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  entry_t        wdat_i,
    input  logic          rd_i,
    output entry_t        rdat_o,
    output logic          full_o,
    output logic          empty_o,
    output logic [LW-1:0] level_o
);
    localparam int AW = $clog2(DEPTH);

    entry_t        mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [LW-1:0] lvl_q;
    logic          push, pop;

    assign full_o  = (lvl_q == LW'(DEPTH));
    assign empty_o = (lvl_q == '0);
    assign push    = wr_i && !full_o;
    assign pop     = rd_i && !empty_o;
    assign rdat_o  = mem[rptr_q];
    assign level_o = lvl_q;

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= wdat_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            lvl_q  <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + 1'b1;
            if (pop)  rptr_q <= rptr_q + 1'b1;
            case ({push, pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // R4: a write into a full ring never raises the level
    p_full_no_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o) |=> (level_o == $past(level_o) - ($past(rd_i) ? 1'b1 : 1'b0)));
endmodule

// File: rtl/rxq_rts_fsm.sv
module rxq_rts_fsm
    import rxq_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] hi_i,
    input  logic [LW-1:0] lo_i,
    output logic          rts_o
);
    rts_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_OPEN: if (level_i >= hi_i) state_d = RTS_HELD;
            RTS_HELD: if (level_i <  lo_i) state_d = RTS_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RTS_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        rts_o = (state_q == RTS_OPEN);
    end

    // R2: reaching the high mark pauses the peer on the next edge
    p_rts_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i >= hi_i) |=> !rts_o);
    // R3: hysteresis, no release at or above the low mark
    p_rts_hyst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_o && level_i >= lo_i) |=> !rts_o);
endmodule

// File: rtl/rxq_satcnt.sv
module rxq_satcnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)       cnt_q <= '0;
        else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R9: saturation holds and clear wins
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '1 && !clr_i) |=> (cnt_o == '1));
    p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/rxq_flow_top.sv
module rxq_flow_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 8,
    parameter int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid_i,
    input  logic [7:0]    rx_data_i,
    input  logic          rx_ferr_i,
    input  logic          rx_break_i,
    output logic          m_valid_o,
    input  logic          m_ready_i,
    output logic [7:0]    m_data_o,
    output logic [1:0]    m_kind_o,
    output logic          rts_o,
    input  logic          cts_i,
    input  logic          tx_in_valid_i,
    input  logic [7:0]    tx_in_data_i,
    output logic          tx_in_ready_o,
    output logic          tx_out_valid_o,
    output logic [7:0]    tx_out_data_o,
    input  logic          tx_out_ready_i,
    input  logic          cfg_wr_i,
    input  logic [LW-1:0] cfg_hi_i,
    input  logic [LW-1:0] cfg_lo_i,
    input  logic          clr_i,
    output logic [CW-1:0] ovr_cnt_o,
    output logic [CW-1:0] und_cnt_o,
    output logic          ovf_evt_o
);
    localparam logic [LW-1:0] HI_DEF = LW'((DEPTH * 3) / 4);
    localparam logic [LW-1:0] LO_DEF = LW'(DEPTH / 4);

    entry_t        wentry, head;
    logic          full, empty, drop, under, ovf_q;
    logic [LW-1:0] level, hi_q, lo_q;
    logic          cfg_ok;

    // entry tagging: break outranks framing error
    always_comb begin
        wentry.data = rx_data_i;
        if (rx_break_i) begin
            wentry.kind = K_BREAK;
            wentry.data = '0;
        end else if (rx_ferr_i) begin
            wentry.kind = K_FERR;
        end else begin
            wentry.kind = K_DATA;
        end
    end

    rxq_ring #(.DEPTH(DEPTH), .LW(LW)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_i(rx_valid_i), .wdat_i(wentry),
        .rd_i(m_ready_i), .rdat_o(head),
        .full_o(full), .empty_o(empty), .level_o(level)
    );

    assign m_valid_o = !empty;
    assign m_data_o  = head.data;
    assign m_kind_o  = head.kind;

    // watermark registers with legality fallback
    assign cfg_ok = (cfg_lo_i < cfg_hi_i) && (cfg_hi_i <= LW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= HI_DEF;
            lo_q <= LO_DEF;
        end else if (cfg_wr_i) begin
            hi_q <= cfg_ok ? cfg_hi_i : HI_DEF;
            lo_q <= cfg_ok ? cfg_lo_i : LO_DEF;
        end
    end

    rxq_rts_fsm #(.LW(LW)) u_rts (
        .clk(clk), .rst_n(rst_n),
        .level_i(level), .hi_i(hi_q), .lo_i(lo_q),
        .rts_o(rts_o)
    );

    assign drop  = rx_valid_i && full;
    assign under = m_ready_i && empty;

    rxq_satcnt #(.CW(CW)) u_ovr (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(drop), .cnt_o(ovr_cnt_o)
    );
    rxq_satcnt #(.CW(CW)) u_und (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(under), .cnt_o(und_cnt_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= drop;
    end
    assign ovf_evt_o = ovf_q;

    // transmit gate on clear-to-send
    assign tx_out_valid_o = tx_in_valid_i && cts_i;
    assign tx_out_data_o  = tx_in_data_i;
    assign tx_in_ready_o  = tx_out_ready_i && cts_i;

    // R4: each byte offered to a full queue is counted
    p_overrun_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !m_valid_o ? 1'b0 : (rx_valid_i && full && !clr_i && ovr_cnt_o != '1))
        |=> (ovr_cnt_o == $past(ovr_cnt_o) + 1'b1));
    // R6: a read request on an empty queue is counted
    p_underrun_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ready_i && !m_valid_o && !clr_i && und_cnt_o != '1)
        |=> (und_cnt_o == $past(und_cnt_o) + 1'b1));
endmodule

// File: tb/sim_rxq_flow_top.sv
module sim_rxq_flow_top;
    localparam int DEPTH = 16;
    localparam int CW    = 8;
    localparam int LW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rx_ferr = 0, rx_break = 0;
    logic [7:0] rx_data = 0;
    logic m_valid, m_ready = 0;
    logic [7:0] m_data;
    logic [1:0] m_kind;
    logic rts, cts = 1;
    logic tx_in_valid = 0, tx_in_ready, tx_out_valid, tx_out_ready = 0;
    logic [7:0] tx_in_data = 0, tx_out_data;
    logic cfg_wr = 0, clr = 0;
    logic [LW-1:0] cfg_hi = 0, cfg_lo = 0;
    logic [CW-1:0] ovr_cnt, und_cnt;
    logic ovf_evt;

    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxq_flow_top #(.DEPTH(DEPTH), .CW(CW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ferr_i(rx_ferr), .rx_break_i(rx_break),
        .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data), .m_kind_o(m_kind),
        .rts_o(rts), .cts_i(cts),
        .tx_in_valid_i(tx_in_valid), .tx_in_data_i(tx_in_data), .tx_in_ready_o(tx_in_ready),
        .tx_out_valid_o(tx_out_valid), .tx_out_data_o(tx_out_data), .tx_out_ready_i(tx_out_ready),
        .cfg_wr_i(cfg_wr), .cfg_hi_i(cfg_hi), .cfg_lo_i(cfg_lo), .clr_i(clr),
        .ovr_cnt_o(ovr_cnt), .und_cnt_o(und_cnt), .ovf_evt_o(ovf_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input bit fe = 0, input bit brk = 0);
        rx_valid = 1; rx_data = d; rx_ferr = fe; rx_break = brk;
        tick();
        rx_valid = 0; rx_ferr = 0; rx_break = 0;
    endtask

    task automatic pop_exp(input int d, input int k, input string req);
        chk(m_valid == 1, req, m_valid, 1);
        chk(m_data == d[7:0] && m_kind == k[1:0], req, {m_kind, m_data}, {k[1:0], d[7:0]});
        m_ready = 1;
        tick();
        m_ready = 0;
    endtask

    task automatic t_reset;  // R11
        chk(m_valid == 0, "R11 empty", m_valid, 0);
        chk(rts == 1, "R11 rts", rts, 1);
        chk(ovr_cnt == 0 && und_cnt == 0, "R11 counters", ovr_cnt + und_cnt, 0);
    endtask

    task automatic t_order;  // R1 R7
        push(8'h11); push(8'h22, 1); push(8'h00, 0, 1); push(8'h33); push(8'h44, 1, 1);
        pop_exp(8'h11, 0, "R1 data");
        pop_exp(8'h22, 1, "R1 framing tag");
        pop_exp(8'h00, 2, "R7 break tag");
        pop_exp(8'h33, 0, "R7 order after break");
        pop_exp(8'h00, 2, "R1 break beats ferr");
        chk(m_valid == 0, "R1 drained", m_valid, 0);
    endtask

    task automatic t_rts;  // R2 R3
        for (int i = 0; i < 11; i++) push(8'(i));
        tick(2);
        chk(rts == 1, "R2 below high", rts, 1);
        push(8'd11);
        tick(1);
        chk(rts == 0, "R2 at high", rts, 0);
        for (int i = 0; i < 8; i++) pop_exp(i, 0, "R1 ramp order");
        tick(2);
        chk(rts == 0, "R3 at low mark", rts, 0);
        pop_exp(8, 0, "R1 ramp order");
        tick(2);
        chk(rts == 1, "R3 below low", rts, 1);
        for (int i = 9; i < 12; i++) pop_exp(i, 0, "R1 ramp order");
    endtask

    task automatic t_overrun;  // R4 R5
        for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
        chk(ovf_evt == 0, "R5 no drop yet", ovf_evt, 0);
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1; rx_data = 8'hEE;
            tick();
            chk(ovf_evt == 1, "R5 pulse", ovf_evt, 1);
            rx_valid = 0;
            tick();
            chk(ovf_evt == 0, "R5 single cycle", ovf_evt, 0);
        end
        chk(ovr_cnt == 3, "R4 drop count", ovr_cnt, 3);
        for (int i = 0; i < 16; i++) pop_exp(8'h40 + i, 0, "R4 contents kept");
        clr = 1; tick(); clr = 0;
        chk(ovr_cnt == 0, "R9 clear", ovr_cnt, 0);
    endtask

    task automatic t_underrun;  // R6
        m_ready = 1; tick(3); m_ready = 0;
        chk(und_cnt == 3, "R6 underrun count", und_cnt, 3);
        chk(ovr_cnt == 0, "R6 separate from overrun", ovr_cnt, 0);
        push(8'h5A);
        pop_exp(8'h5A, 0, "R6 contents unaffected");
    endtask

    task automatic t_saturate;  // R9
        for (int i = 0; i < 16; i++) push(8'(i));
        rx_valid = 1; tick(260); rx_valid = 0;
        tick();
        chk(ovr_cnt == 255, "R9 saturate", ovr_cnt, 255);
        clr = 1; rx_valid = 1; tick(); clr = 0; rx_valid = 0;
        chk(ovr_cnt == 0 && und_cnt == 0, "R9 clear over inc", ovr_cnt + und_cnt, 0);
        for (int i = 0; i < 16; i++) pop_exp(i, 0, "R4 contents after drops");
    endtask

    task automatic t_cts;  // R8
        tx_in_valid = 1; tx_in_data = 8'hC3; tx_out_ready = 1; cts = 0;
        tick();
        chk(tx_out_valid == 0 && tx_in_ready == 0, "R8 blocked", {tx_out_valid, tx_in_ready}, 0);
        cts = 1;
        tick();
        chk(tx_out_valid == 1 && tx_in_ready == 1 && tx_out_data == 8'hC3, "R8 pass",
            {tx_out_valid, tx_in_ready}, 3);
        tx_in_valid = 0; tx_out_ready = 0;
    endtask

    task automatic cfg(input int hi, input int lo);
        cfg_hi = LW'(hi); cfg_lo = LW'(lo); cfg_wr = 1; tick(); cfg_wr = 0;
    endtask

    task automatic t_cfg;  // R10
        cfg(8, 2);
        for (int i = 0; i < 7; i++) push(8'(i));
        tick(2);
        chk(rts == 1, "R10 custom below high", rts, 1);
        push(8'd7); tick(2);
        chk(rts == 0, "R10 custom high", rts, 0);
        for (int i = 0; i < 6; i++) pop_exp(i, 0, "R10 order");
        tick(2);
        chk(rts == 0, "R10 custom at low", rts, 0);
        pop_exp(6, 0, "R10 order"); tick(2);
        chk(rts == 1, "R10 custom below low", rts, 1);
        pop_exp(7, 0, "R10 order");
        for (int v = 0; v < 2; v++) begin
            if (v == 0) cfg(5, 5); else cfg(17, 2);
            for (int i = 0; i < 11; i++) push(8'(i));
            tick(2);
            chk(rts == 1, "R10 default below high", rts, 1);
            push(8'd11); tick(2);
            chk(rts == 0, "R10 default high", rts, 0);
            for (int i = 0; i < 12; i++) pop_exp(i, 0, "R10 order");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        t_reset();
        t_order();
        t_rts();
        t_overrun();
        t_underrun();
        t_saturate();
        t_cts();
        t_cfg();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule